// File: doc/BRIEF.md
# Paired-Channel Up/Down Event Counter

This block counts events seen on two timer input pins that work as a pair. The primary pin owns the count. The partner pin either subtracts from it or steers its direction. Each pin passes through a synchronizer and then an edge detector. The edge detector's polarity is set by a per-channel edge-select field. A per-channel capture-mode field chooses the behaviour, and the two channels must agree on it.

- In up/down mode, qualified edges on the primary pin add one and qualified edges on the partner pin subtract one.
- In rotary mode, only the primary pin's edges count. The level of the synchronized partner pin at that moment sets the direction, as in a simple quadrature decoder.

Software configures the block through a small write/read register port. It reads the count but cannot change it. It collects sticky wrap flags, which are cleared by writing 1, and can enable each flag onto one interrupt line.

The mode control is a three-state machine:

- **States:** `ST_IDLE` (no counting), `ST_UPDN` (up/down counting) and `ST_ROT` (rotary counting).
- **Transitions:** from any state, the machine moves to `ST_UPDN` when both mode fields hold 0b10, to `ST_ROT` when both hold 0b11, and to `ST_IDLE` for any other combination.
- **Count clear:** every change of state clears the count to zero in the same cycle as the change.

Top module: `pair_evcnt`

## Requirements
- R1: After reset the count reads 0, both wrap flags read 0 and `irq` is low.
- R2: Counting happens only when both channels' mode fields (bits 3:2 of config registers 0 and 1) equal each other and are 0b10 (up/down) or 0b11 (rotary). Any other combination ignores all pin edges and the count holds.
- R3: In up/down mode, a qualified primary edge adds 1 and a qualified partner edge subtracts 1. When both occur in the same cycle, the count is unchanged.
- R4: Each channel's edge select (bits 1:0 of its config register) chooses which edges qualify: 00 none, 01 rising, 10 falling, 11 both.
- R5: In rotary mode, a qualified primary edge adds 1 when the synchronized partner level is 0 and subtracts 1 when it is 1. Edges on the partner pin never change the count.
- R6: A pin change applied between clock edges shows in the count after the third rising clock edge that follows, and not after the second.
- R7: The count is CNT_W bits wide and wraps. Stepping up from all-ones to 0 sets the overflow flag (bit 0 of register 3). Stepping down from 0 to all-ones sets the underflow flag (bit 1).
- R8: The wrap flags are sticky. Writing 1 to a bit of register 3 clears that flag, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when a flag is set and its enable bit in register 2 (bit 0 overflow, bit 1 underflow) is set.
- R10: The count is read at register 4, and writes to register 4 have no effect on it.
- R11: Any change of the effective mode (idle, up/down or rotary) clears the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_pri | input | 1 | Primary channel input pin |
| pin_par | input | 1 | Partner channel input pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data, combinational from `rd_addr` |
| irq | output | 1 | Wrap interrupt |

## Verification
The bench builds the block with CNT_W = 8 and keeps the default DATA_W, ADDR_W and SYNC_STAGES. The narrow counter lets a random walk of pin edges cross both wrap points within a short run, so overflow and underflow arise from free-running stimulus and not only from the directed steps. The default two-stage synchronizer fixes the three-edge latency that the bench model replays against its own pin history.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UPDN = 2'd1,
        ST_ROT  = 2'd2
    } evc_state_t;

    localparam logic [1:0] MODE_UPDN = 2'b10;
    localparam logic [1:0] MODE_ROT  = 2'b11;

    localparam logic [1:0] EDGE_OFF  = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    localparam int unsigned REG_PCFG = 0;
    localparam int unsigned REG_QCFG = 1;
    localparam int unsigned REG_IEN  = 2;
    localparam int unsigned REG_FLAG = 3;
    localparam int unsigned REG_CNT  = 4;

    localparam int unsigned CFG_W  = 4;
    localparam int unsigned NFLAG  = 2;
    localparam int unsigned FLG_OV = 0;
    localparam int unsigned FLG_UN = 1;

endpackage

// File: rtl/evc_edge.sv
module evc_edge
    import evc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       lvl,
    output logic       evt
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   rise;
    logic                   fall;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[SYNC_STAGES-2:0], pin};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= pin;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= chain[SYNC_STAGES-1];
        end
    end

    assign lvl  = chain[SYNC_STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    always_comb begin
        unique case (sel)
            EDGE_OFF:  evt = 1'b0;
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            EDGE_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/evc_mode_fsm.sv
module evc_mode_fsm
    import evc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pri_mode,
    input  logic [1:0] par_mode,
    input  logic       pri_evt,
    input  logic       par_evt,
    input  logic       par_lvl,
    output evc_state_t state,
    output logic       clr,
    output logic       inc,
    output logic       dec
);

    evc_state_t next_state;

    always_comb begin
        if (pri_mode == par_mode && pri_mode == MODE_UPDN) begin
            next_state = ST_UPDN;
        end else if (pri_mode == par_mode && pri_mode == MODE_ROT) begin
            next_state = ST_ROT;
        end else begin
            next_state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    always_comb begin
        clr = (next_state != state);
        inc = 1'b0;
        dec = 1'b0;
        unique case (state)
            ST_IDLE: begin
                inc = 1'b0;
                dec = 1'b0;
            end
            ST_UPDN: begin
                inc = pri_evt;
                dec = par_evt;
            end
            ST_ROT: begin
                inc = pri_evt & ~par_lvl;
                dec = pri_evt & par_lvl;
            end
            default: begin
                inc = 1'b0;
                dec = 1'b0;
            end
        endcase
    end

    AST_ROT_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROT) |-> !(inc && dec)); // R5

    AST_CLR_MOVES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state != $past(state))); // R11

endmodule

// File: rtl/evc_count.sv
module evc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             wrap_up,
    output logic             wrap_dn
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic step_up;
    logic step_dn;

    assign step_up = inc & ~dec & ~clr;
    assign step_dn = dec & ~inc & ~clr;
    assign wrap_up = step_up && (count == CNT_MAX);
    assign wrap_dn = step_dn && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (step_up) begin
            count <= count + 1'b1;
        end else if (step_dn) begin
            count <= count - 1'b1;
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R11

    AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec && !clr) |=> (count == $past(count))); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1
                  || count == $past(count) - 1'b1)); // R3

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up |=> (count == '0)); // R7

endmodule

// File: rtl/pair_evcnt.sv
module pair_evcnt
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_pri,
    input  logic              pin_par,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int NCH = 2;

    logic [CFG_W-1:0]         pri_cfg;
    logic [CFG_W-1:0]         par_cfg;
    logic [NFLAG-1:0]         ien;
    logic [NFLAG-1:0]         flags;
    logic [NFLAG-1:0]         flag_set;
    logic [NFLAG-1:0]         flag_w1c;
    logic [NCH-1:0]           pins;
    logic [NCH-1:0]           lvl;
    logic [NCH-1:0]           evt;
    logic [NCH-1:0][1:0]      sel;
    logic                     wr_pcfg;
    logic                     wr_qcfg;
    logic                     wr_ien;
    logic                     wr_flag;
    evc_state_t               state;
    logic                     clr;
    logic                     inc;
    logic                     dec;
    logic [CNT_W-1:0]         count;
    logic                     wrap_up;
    logic                     wrap_dn;
    logic                     unused_bits;

    assign wr_pcfg = wr_en && (wr_addr == ADDR_W'(REG_PCFG));
    assign wr_qcfg = wr_en && (wr_addr == ADDR_W'(REG_QCFG));
    assign wr_ien  = wr_en && (wr_addr == ADDR_W'(REG_IEN));
    assign wr_flag = wr_en && (wr_addr == ADDR_W'(REG_FLAG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_cfg <= '0;
            par_cfg <= '0;
            ien     <= '0;
        end else begin
            if (wr_pcfg) pri_cfg <= wr_data[CFG_W-1:0];
            if (wr_qcfg) par_cfg <= wr_data[CFG_W-1:0];
            if (wr_ien)  ien     <= wr_data[NFLAG-1:0];
        end
    end

    assign pins   = {pin_par, pin_pri};
    assign sel[0] = pri_cfg[1:0];
    assign sel[1] = par_cfg[1:0];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            evc_edge #(
                .SYNC_STAGES (SYNC_STAGES)
            ) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (pins[g]),
                .sel   (sel[g]),
                .lvl   (lvl[g]),
                .evt   (evt[g])
            );
        end
    endgenerate

    evc_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_mode (pri_cfg[3:2]),
        .par_mode (par_cfg[3:2]),
        .pri_evt  (evt[0]),
        .par_evt  (evt[1]),
        .par_lvl  (lvl[1]),
        .state    (state),
        .clr      (clr),
        .inc      (inc),
        .dec      (dec)
    );

    evc_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .inc     (inc),
        .dec     (dec),
        .count   (count),
        .wrap_up (wrap_up),
        .wrap_dn (wrap_dn)
    );

    assign flag_set[FLG_OV] = wrap_up;
    assign flag_set[FLG_UN] = wrap_dn;
    assign flag_w1c         = wr_flag ? wr_data[NFLAG-1:0] : '0;

    generate
        for (genvar f = 0; f < NFLAG; f++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[f] <= 1'b0;
                end else begin
                    flags[f] <= flag_set[f] | (flags[f] & ~flag_w1c[f]);
                end
            end
        end
    endgenerate

    assign irq = |(flags & ien);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_PCFG)) begin
            rd_data[CFG_W-1:0] = pri_cfg;
        end else if (rd_addr == ADDR_W'(REG_QCFG)) begin
            rd_data[CFG_W-1:0] = par_cfg;
        end else if (rd_addr == ADDR_W'(REG_IEN)) begin
            rd_data[NFLAG-1:0] = ien;
        end else if (rd_addr == ADDR_W'(REG_FLAG)) begin
            rd_data[NFLAG-1:0] = flags;
        end else if (rd_addr == ADDR_W'(REG_CNT)) begin
            rd_data[CNT_W-1:0] = count;
        end
    end

    assign unused_bits = ^{wr_data[DATA_W-1:CFG_W], lvl[0]};

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !clr) |=> $stable(count)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_OV] && !flag_w1c[FLG_OV]) |=> flags[FLG_OV]); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0)); // R9

    AST_COUNT_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REG_CNT) && !inc && !dec && !clr)
        |=> $stable(count)); // R10

endmodule

// File: tb/pair_evcnt_tb_top.sv
module pair_evcnt_tb_top;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int CMAX   = (1 << CNT_W) - 1;

    localparam logic [ADDR_W-1:0] A_PCFG = 3'd0;
    localparam logic [ADDR_W-1:0] A_QCFG = 3'd1;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pin_pri = 1'b0;
    logic              pin_par = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model state
    logic [3:0] m_pcfg = 4'h0;
    logic [3:0] m_qcfg = 4'h0;
    int         m_mode = 0;
    int         m_cnt  = 0;
    bit         m_of   = 1'b0;
    bit         m_uf   = 1'b0;
    bit h1p = 0, h2p = 0, h3p = 0, h1q = 0, h2q = 0, h3q = 0;

    always #2 clk = ~clk;

    pair_evcnt #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_pri (pin_pri),
        .pin_par (pin_par),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic bit f_evt(input logic [1:0] s, input bit cur, input bit prv);
        case (s)
            2'b01:   return cur & !prv;
            2'b10:   return !cur & prv;
            2'b11:   return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int f_mode(input logic [3:0] p, input logic [3:0] q);
        if (p[3:2] == q[3:2] && p[3:2] == 2'b10) return 1;
        if (p[3:2] == q[3:2] && p[3:2] == 2'b11) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit pe, qe, up, dn;
        if (rst_n) begin
            pe = f_evt(m_pcfg[1:0], h2p, h3p);
            qe = f_evt(m_qcfg[1:0], h2q, h3q);
            up = 1'b0;
            dn = 1'b0;
            if (m_mode == 1) begin
                up = pe;
                dn = qe;
            end else if (m_mode == 2) begin
                up = pe & !h2q;
                dn = pe & h2q;
            end
            if (up && !dn) begin
                if (m_cnt == CMAX) begin m_cnt = 0; m_of = 1'b1; end
                else m_cnt = m_cnt + 1;
            end else if (dn && !up) begin
                if (m_cnt == 0) begin m_cnt = CMAX; m_uf = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
            h3p = h2p; h2p = h1p; h1p = pin_pri;
            h3q = h2q; h2q = h1q; h1q = pin_par;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic tog(input bit a, input bit b);
        @(negedge clk);
        if (a) pin_pri = ~pin_pri;
        if (b) pin_par = ~pin_par;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic set_cfg(input logic [3:0] p, input logic [3:0] q);
        int nm;
        wr(A_PCFG, {12'h0, p});
        wr(A_QCFG, {12'h0, q});
        repeat (2) @(posedge clk);
        @(negedge clk);
        nm = f_mode(p, q);
        if (nm != m_mode) m_cnt = 0;
        m_pcfg = p; m_qcfg = q; m_mode = nm;
    endtask

    task automatic clr_flags(input logic [1:0] v);
        wr(A_FLAG, {14'h0, v});
        if (v[0]) m_of = 1'b0;
        if (v[1]) m_uf = 1'b0;
    endtask

    task automatic cmp_model(input string tag);
        int v;
        rd(A_CNT, v);
        chk({tag, " count"}, v, m_cnt);
        rd(A_FLAG, v);
        chk({tag, " flags"}, v, {m_uf, m_of});
    endtask

    task automatic tog_chk(input bit a, input bit b, input string tag, input int exp);
        int v;
        tog(a, b);
        settle();
        rd(A_CNT, v);
        chk(tag, v, exp);
    endtask

    task automatic rand_run(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if ($urandom % 3 == 0) pin_pri = ~pin_pri;
            if ($urandom % 3 == 0) pin_par = ~pin_par;
            if (i % 16 == 15) cmp_model(tag);
        end
        settle();
        cmp_model(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_FLAG, v); chk("R1 flags", v, 0);
        chk("R1 irq", int'(irq), 0);

        // R6 latency, up/down both edges
        set_cfg(4'hB, 4'hB);
        tog(1, 0);
        repeat (2) @(posedge clk);
        rd(A_CNT, v); chk("R6 after two edges", v, 0);
        rd(A_CNT, v); chk("R6 after three edges", v, 1);
        settle();

        // R3 cancel and decrement
        tog_chk(1, 1, "R3 same-cycle cancel", 1);
        tog_chk(0, 1, "R3 partner decrement", 0);

        // R4 edge select per channel
        set_cfg(4'h9, 4'hA);
        tog_chk(1, 0, "R4 primary rise", 1);
        tog_chk(1, 0, "R4 primary fall ignored", 1);
        tog_chk(0, 1, "R4 partner rise ignored", 1);
        tog_chk(0, 1, "R4 partner fall", 0);
        set_cfg(4'h8, 4'h8);
        tog_chk(1, 1, "R4 select off rise", 0);
        tog_chk(1, 1, "R4 select off fall", 0);

        // R5 rotary
        set_cfg(4'hD, 4'hC);
        tog_chk(1, 0, "R5 rise with partner low", 1);
        tog_chk(1, 0, "R5 fall not selected", 1);
        tog_chk(0, 1, "R5 partner edge ignored", 1);
        tog_chk(1, 0, "R5 rise with partner high", 0);
        tog_chk(1, 0, "R5 fall not selected again", 0);
        tog_chk(0, 1, "R5 partner edge ignored again", 0);

        // R2 mismatched modes ignore edges
        set_cfg(4'hB, 4'hF);
        tog_chk(1, 1, "R2 mismatch hold", 0);
        tog_chk(1, 0, "R2 mismatch hold primary", 0);
        tog_chk(1, 0, "R2 mismatch hold primary back", 0);

        // R7 wrap flags, R9 interrupt, R8 clear
        set_cfg(4'hB, 4'hB);
        wr(A_IEN, 16'h2);
        tog_chk(0, 1, "R7 underflow wrap", CMAX);
        rd(A_FLAG, v); chk("R7 underflow flag", v, 2);
        chk("R9 irq on enabled underflow", int'(irq), 1);
        tog_chk(1, 0, "R7 overflow wrap", 0);
        rd(A_FLAG, v); chk("R7 overflow flag", v, 3);
        clr_flags(2'b01);
        rd(A_FLAG, v); chk("R8 write one clears", v, 2);
        clr_flags(2'b00);
        rd(A_FLAG, v); chk("R8 write zero keeps", v, 2);
        wr(A_IEN, 16'h1);
        chk("R9 irq masked flag", int'(irq), 0);
        clr_flags(2'b10);
        rd(A_FLAG, v); chk("R8 clear underflow", v, 0);

        // R10 count not writable
        tog_chk(1, 0, "R10 setup count", 1);
        wr(A_CNT, 16'h0055);
        rd(A_CNT, v); chk("R10 write ignored", v, 1);

        // R11 mode change clears
        set_cfg(4'hF, 4'hF);
        rd(A_CNT, v); chk("R11 cleared on mode change", v, 0);

        // random up/down (R3 R4 R7)
        set_cfg(4'hB, 4'hB);
        clr_flags(2'b11);
        rand_run(3000, "R3 random updown");

        // random rotary (R5 R7)
        set_cfg(4'hF, 4'hC);
        clr_flags(2'b11);
        rand_run(3000, "R5 random rotary");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule